// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is a single-channel DMA engine. It moves a programmed number of data items between a peripheral location and a memory location through a single-beat read/write bus master port. Each item is framed by a request/acknowledge exchange with the peripheral. For every item the engine reads from the source, writes to the destination, and then decrements its remaining-item counter.

The programmed base addresses, sizes, increment enables and direction are sampled when the channel starts. Two separate current pointers then step through the transfer, so the programmed bases are never modified. When the peripheral and memory sizes differ, the item is zero-extended or truncated. No packing is done. When the count runs out, the engine raises a completion flag and ignores all further requests until the channel is disabled and enabled again.

States are `ST_IDLE`, `ST_WAIT_REQ`, `ST_READ`, `ST_WRITE`, `ST_ACK` and `ST_DONE`. Transitions:
- IDLE→WAIT_REQ on enable with legal sizes and a non-zero count.
- IDLE→DONE on enable with legal sizes and a zero count.
- WAIT_REQ→READ on a request.
- WAIT_REQ→IDLE on disable.
- READ→WRITE when the read beat is accepted.
- WRITE→ACK when the write beat is accepted.
- ACK→WAIT_REQ when the request drops and items remain.
- ACK→DONE when the request drops and no items remain.
- DONE→IDLE on disable.

Top module: `dma_chan_seq`

## Requirements
- R1: The first item is read from the base address of the source side and written to the base address of the destination side. Each item uses one read beat (`bus_write`=0) followed by one write beat (`bus_write`=1).
- R2: When a side's increment enable is 1, its current address grows after each item by 1, 2 or 4 for size codes 00 (8-bit), 01 (16-bit) and 10 (32-bit).
- R3: When a side's increment enable is 0, every item on that side uses the same address.
- R4: With `xfer_dir`=0 the peripheral side is read and memory is written. With `xfer_dir`=1 memory is read and the peripheral side is written.
- R5: Data is right-aligned on the bus. The written value is the read value masked to the source width and then to the destination width. `bus_size` carries the size code of the side being accessed.
- R6: `items_left` loads the 16-bit count one cycle after enable. It drops by exactly one when each write beat is accepted, and it reaches 0xFFFF for the largest count.
- R7: `periph_ack` rises after the write beat and stays high while `periph_req` is high. It falls on the cycle after `periph_req` falls. No new item starts while it is high.
- R8: After the last item, `xfer_done` is 1. Further requests cause no bus beat and no acknowledge until the channel is disabled.
- R9: Enabling with a count of zero sets `xfer_done` on the next cycle, with no bus beat.
- R10: A size code of 11 on either side keeps the channel idle: no beat, no acknowledge, no done, and `items_left` unchanged.
- R11: Disabling and re-enabling restarts the transfer from the programmed base addresses.
- R12: While `bus_valid` is high and `bus_ready` is low, the address, size and write flag stay stable.
- R13: After reset, `xfer_done`, `periph_ack` and `bus_valid` are 0 and `items_left` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| xfer_dir | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| item_count | input | 16 | Number of items to move |
| periph_base | input | AW | Programmed peripheral address |
| mem_base | input | AW | Programmed memory address |
| periph_size | input | 2 | Peripheral item size code |
| mem_size | input | 2 | Memory item size code |
| periph_inc | input | 1 | Peripheral pointer increment enable |
| mem_inc | input | 1 | Memory pointer increment enable |
| periph_req | input | 1 | Peripheral item request |
| periph_ack | output | 1 | Item acknowledge to peripheral |
| bus_valid | output | 1 | Bus beat valid |
| bus_write | output | 1 | Beat is a write |
| bus_addr | output | AW | Beat address |
| bus_size | output | 2 | Beat size code |
| bus_wdata | output | DW | Write data, right-aligned |
| bus_rdata | input | DW | Read data, right-aligned |
| bus_ready | input | 1 | Beat accepted this cycle |
| items_left | output | 16 | Remaining item count |
| xfer_done | output | 1 | Transfer complete |

## Verification
Two events can fall in the same cycle: the counter reaching zero as the final acknowledge is released, and a fresh request from the peripheral. The bench re-raises the request on the very cycle the acknowledge falls after the last item. It passes only if `xfer_done` is high and no further read beat or acknowledge appears. A second overlap is a bus stall while the engine moves between read and write. Vectors with bus wait states check that the address held across the stall still matches the expected pointer, and that the count drops only once per item.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_READ,
        ST_WRITE,
        ST_ACK,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } item_size_t;

    localparam int unsigned SIDE_PERIPH = 0;
    localparam int unsigned SIDE_MEM    = 1;
    localparam int unsigned NUM_SIDES   = 2;

endpackage

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit
    import dma_seq_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          inc_en,
    input  item_size_t    size,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] cur
);

    logic [AW-1:0] cur_q;
    logic [AW-1:0] stride;

    always_comb begin
        unique case (size)
            SZ_BYTE: stride = AW'(1);
            SZ_HALF: stride = AW'(2);
            default: stride = AW'(4);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (load) begin
            cur_q <= base;
        end else if (step && inc_en) begin
            cur_q <= cur_q + stride;
        end
    end

    assign cur = cur_q;

    a_r1_load_base: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_q == $past(base));

    a_r2_ptr_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (step && inc_en && !load) |=> (cur_q - $past(cur_q)) == $past(stride));

    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !inc_en && !load) |=> $stable(cur_q));

endmodule

// File: rtl/dma_item_count.sv
module dma_item_count #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] init,
    input  logic          dec,
    output logic [CW-1:0] remain,
    output logic          zero
);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= init;
        end else if (dec) begin
            remain_q <= remain_q - CW'(1);
        end
    end

    assign remain = remain_q;
    assign zero   = (remain_q == '0);

    a_r6_dec_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> remain_q == $past(remain_q) - CW'(1));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !load) |=> $stable(remain_q));

    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> remain_q != '0);

endmodule

// File: rtl/dma_data_path.sv
module dma_data_path
    import dma_seq_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] rdata,
    input  item_size_t    src_size,
    input  item_size_t    dst_size,
    output logic [DW-1:0] wdata
);

    logic [DW-1:0] item_q;
    logic [DW-1:0] src_mask;
    logic [DW-1:0] dst_mask;

    function automatic logic [DW-1:0] width_mask(input item_size_t sz);
        logic [DW-1:0] m;
        unique case (sz)
            SZ_BYTE: m = DW'(32'h0000_00FF);
            SZ_HALF: m = DW'(32'h0000_FFFF);
            default: m = '1;
        endcase
        return m;
    endfunction

    always_comb begin
        src_mask = width_mask(src_size);
        dst_mask = width_mask(dst_size);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            item_q <= '0;
        end else if (capture) begin
            item_q <= rdata & src_mask & dst_mask;
        end
    end

    assign wdata = item_q;

    a_r5_item_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(item_q));

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_en,
    input  logic       cfg_ok,
    input  logic       count_init_zero,
    input  logic       remain_zero,
    input  logic       periph_req,
    input  logic       bus_ready,
    output seq_state_t state,
    output logic       start_load,
    output logic       rd_capture,
    output logic       wr_done,
    output logic       bus_valid,
    output logic       bus_write,
    output logic       periph_ack,
    output logic       xfer_done
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (chan_en && cfg_ok) begin
                    state_d = count_init_zero ? ST_DONE : ST_WAIT_REQ;
                end
            end
            ST_WAIT_REQ: begin
                if (!chan_en) begin
                    state_d = ST_IDLE;
                end else if (periph_req) begin
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (bus_ready) begin
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (bus_ready) begin
                    state_d = ST_ACK;
                end
            end
            ST_ACK: begin
                if (!periph_req) begin
                    state_d = remain_zero ? ST_DONE : ST_WAIT_REQ;
                end
            end
            ST_DONE: begin
                if (!chan_en) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        start_load = (state_q == ST_IDLE) && chan_en && cfg_ok;
        rd_capture = (state_q == ST_READ) && bus_ready;
        wr_done    = (state_q == ST_WRITE) && bus_ready;
        bus_valid  = (state_q == ST_READ) || (state_q == ST_WRITE);
        bus_write  = (state_q == ST_WRITE);
        periph_ack = (state_q == ST_ACK);
        xfer_done  = (state_q == ST_DONE);
    end

    assign state = state_q;

    a_r7_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_ack && periph_req) |=> periph_ack);

    a_r7_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_ack && !periph_req) |=> !periph_ack);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && chan_en) |=> (xfer_done && !bus_valid && !periph_ack));

    a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && chan_en && cfg_ok && count_init_zero) |=> xfer_done);

    a_r10_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !cfg_ok) |=> state_q == ST_IDLE);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    input  logic          xfer_dir,
    input  logic [CW-1:0] item_count,
    input  logic [AW-1:0] periph_base,
    input  logic [AW-1:0] mem_base,
    input  logic [1:0]    periph_size,
    input  logic [1:0]    mem_size,
    input  logic          periph_inc,
    input  logic          mem_inc,
    input  logic          periph_req,
    output logic          periph_ack,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    output logic [CW-1:0] items_left,
    output logic          xfer_done
);

    localparam int unsigned SIDE_IDX_W = $clog2(NUM_SIDES);

    seq_state_t state;
    logic       start_load;
    logic       rd_capture;
    logic       wr_done;
    logic       cfg_ok;
    logic       count_init_zero;
    logic       remain_zero;

    logic       dir_q;
    item_size_t size_q [NUM_SIDES];
    logic       inc_q  [NUM_SIDES];
    logic [AW-1:0] base_in  [NUM_SIDES];
    item_size_t    size_in  [NUM_SIDES];
    logic          inc_in   [NUM_SIDES];
    logic [AW-1:0] side_cur [NUM_SIDES];

    logic [SIDE_IDX_W-1:0] src_side;
    logic [SIDE_IDX_W-1:0] dst_side;

    always_comb begin
        cfg_ok          = (periph_size != 2'b11) && (mem_size != 2'b11);
        count_init_zero = (item_count == '0);
        base_in[SIDE_PERIPH] = periph_base;
        base_in[SIDE_MEM]    = mem_base;
        size_in[SIDE_PERIPH] = item_size_t'(periph_size);
        size_in[SIDE_MEM]    = item_size_t'(mem_size);
        inc_in[SIDE_PERIPH]  = periph_inc;
        inc_in[SIDE_MEM]     = mem_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
        end else if (start_load) begin
            dir_q <= xfer_dir;
        end
    end

    generate
        for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    size_q[s] <= SZ_BYTE;
                    inc_q[s]  <= 1'b0;
                end else if (start_load) begin
                    size_q[s] <= size_in[s];
                    inc_q[s]  <= inc_in[s];
                end
            end

            dma_ptr_unit #(
                .AW (AW)
            ) u_ptr (
                .clk    (clk),
                .rst_n  (rst_n),
                .load   (start_load),
                .step   (wr_done),
                .inc_en (inc_q[s]),
                .size   (size_q[s]),
                .base   (base_in[s]),
                .cur    (side_cur[s])
            );
        end
    endgenerate

    assign src_side = dir_q ? SIDE_IDX_W'(SIDE_MEM) : SIDE_IDX_W'(SIDE_PERIPH);
    assign dst_side = dir_q ? SIDE_IDX_W'(SIDE_PERIPH) : SIDE_IDX_W'(SIDE_MEM);

    dma_seq_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .chan_en         (chan_en),
        .cfg_ok          (cfg_ok),
        .count_init_zero (count_init_zero),
        .remain_zero     (remain_zero),
        .periph_req      (periph_req),
        .bus_ready       (bus_ready),
        .state           (state),
        .start_load      (start_load),
        .rd_capture      (rd_capture),
        .wr_done         (wr_done),
        .bus_valid       (bus_valid),
        .bus_write       (bus_write),
        .periph_ack      (periph_ack),
        .xfer_done       (xfer_done)
    );

    dma_item_count #(
        .CW (CW)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start_load),
        .init   (item_count),
        .dec    (wr_done),
        .remain (items_left),
        .zero   (remain_zero)
    );

    dma_data_path #(
        .DW (DW)
    ) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (rd_capture),
        .rdata    (bus_rdata),
        .src_size (size_q[src_side]),
        .dst_size (size_q[dst_side]),
        .wdata    (bus_wdata)
    );

    always_comb begin
        if (bus_write) begin
            bus_addr = side_cur[dst_side];
            bus_size = size_q[dst_side];
        end else begin
            bus_addr = side_cur[src_side];
            bus_size = size_q[src_side];
        end
    end

    a_r12_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=>
            (bus_valid && $stable(bus_addr) && $stable(bus_size) && $stable(bus_write)));

    a_r1_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_ready) |=> (bus_valid && bus_write));

    a_r7_no_item_during_ack: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |-> !bus_valid);

    a_r13_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!bus_valid && !periph_ack && !xfer_done));

endmodule

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;

    typedef struct packed {
        logic        dir;
        logic [1:0]  ps;
        logic [1:0]  ms;
        logic        pi;
        logic        mi;
        logic [7:0]  cnt;
        logic [31:0] pb;
        logic [31:0] mb;
        logic [1:0]  lat;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'b10, 2'b10, 1'b0, 1'b1, 8'd4, 32'h4000_0010, 32'h2000_0100, 2'd0},
        '{1'b1, 2'b01, 2'b00, 1'b1, 1'b1, 8'd3, 32'h4000_1000, 32'h2000_0201, 2'd2},
        '{1'b0, 2'b00, 2'b10, 1'b1, 1'b0, 8'd5, 32'h4000_0203, 32'h2000_0300, 2'd1},
        '{1'b1, 2'b10, 2'b01, 1'b0, 1'b1, 8'd3, 32'h4000_0040, 32'h2000_0402, 2'd0},
        '{1'b0, 2'b01, 2'b01, 1'b1, 1'b1, 8'd2, 32'h4000_0502, 32'h2000_0506, 2'd1},
        '{1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 8'd2, 32'h4000_0601, 32'h2000_0607, 2'd0}
    };

    logic        clk;
    logic        rst_n;
    logic        chan_en;
    logic        xfer_dir;
    logic [15:0] item_count;
    logic [31:0] periph_base;
    logic [31:0] mem_base;
    logic [1:0]  periph_size;
    logic [1:0]  mem_size;
    logic        periph_inc;
    logic        mem_inc;
    logic        periph_req;
    logic        periph_ack;
    logic        bus_valid;
    logic        bus_write;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic [15:0] items_left;
    logic        xfer_done;

    dma_chan_seq dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_en     (chan_en),
        .xfer_dir    (xfer_dir),
        .item_count  (item_count),
        .periph_base (periph_base),
        .mem_base    (mem_base),
        .periph_size (periph_size),
        .mem_size    (mem_size),
        .periph_inc  (periph_inc),
        .mem_inc     (mem_inc),
        .periph_req  (periph_req),
        .periph_ack  (periph_ack),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_size    (bus_size),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_ready   (bus_ready),
        .items_left  (items_left),
        .xfer_done   (xfer_done)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int lat = 0;
    int nrd = 0;
    int nwr = 0;
    logic [31:0] rd_addr [64];
    logic [1:0]  rd_size [64];
    logic [31:0] wr_addr [64];
    logic [31:0] wr_data [64];
    logic [1:0]  wr_size [64];

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [31:0] mem_model(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
    endfunction

    function automatic logic [31:0] mask_of(input logic [1:0] sz);
        case (sz)
            2'b00:   return 32'h0000_00FF;
            2'b01:   return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bus responder: ready after `lat` stall cycles, logs each accepted beat.
    initial begin
        int wctr;
        logic was_rdy;
        logic [31:0] held_addr;
        logic held_we;
        wctr = 0;
        held_addr = '0;
        held_we = 1'b0;
        bus_ready = 1'b0;
        bus_rdata = '0;
        forever begin
            @(negedge clk);
            was_rdy = bus_ready;
            bus_ready = 1'b0;
            if (was_rdy || !bus_valid) wctr = 0;
            if (bus_valid) begin
                if (wctr == 0) begin
                    held_addr = bus_addr;
                    held_we = bus_write;
                end
                if (wctr >= lat) begin
                    chk(bus_addr == held_addr && bus_write == held_we,
                        "R12 beat stable across stall", bus_addr, held_addr);
                    bus_ready = 1'b1;
                    if (!bus_write) begin
                        bus_rdata = mem_model(bus_addr);
                        if (nrd < 64) begin
                            rd_addr[nrd] = bus_addr;
                            rd_size[nrd] = bus_size;
                        end
                        nrd++;
                    end else begin
                        if (nwr < 64) begin
                            wr_addr[nwr] = bus_addr;
                            wr_data[nwr] = bus_wdata;
                            wr_size[nwr] = bus_size;
                        end
                        nwr++;
                    end
                end else begin
                    wctr++;
                end
            end
        end
    end

    task automatic do_item(input logic [15:0] exp_left);
        int t;
        int rd_before;
        t = 0;
        periph_req = 1'b1;
        while (!periph_ack && t < 60) begin
            @(negedge clk);
            t++;
        end
        chk(periph_ack, "R7 ack raised after item", 32'(periph_ack), 32'd1);
        chk(items_left == exp_left, "R6 count dropped by one", 32'(items_left), 32'(exp_left));
        rd_before = nrd;
        repeat (2) @(negedge clk);
        chk(periph_ack, "R7 ack held while request high", 32'(periph_ack), 32'd1);
        chk(nrd == rd_before, "R7 no new item during ack", 32'(nrd), 32'(rd_before));
        periph_req = 1'b0;
        @(negedge clk);
        chk(!periph_ack, "R7 ack released after request drop", 32'(periph_ack), 32'd0);
    endtask

    task automatic apply_cfg(input vec_t v);
        xfer_dir    = v.dir;
        periph_size = v.ps;
        mem_size    = v.ms;
        periph_inc  = v.pi;
        mem_inc     = v.mi;
        item_count  = 16'(v.cnt);
        periph_base = v.pb;
        mem_base    = v.mb;
        lat         = int'(v.lat);
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] sb, db, sa, da, ed;
        logic [1:0]  ss, ds;
        logic        si, di;
        chan_en = 1'b0;
        @(negedge clk);
        apply_cfg(v);
        nrd = 0;
        nwr = 0;
        chan_en = 1'b1;
        @(negedge clk);
        chk(items_left == 16'(v.cnt), "R6 count loaded", 32'(items_left), 32'(v.cnt));
        for (int i = 0; i < int'(v.cnt); i++) begin
            do_item(16'(int'(v.cnt) - 1 - i));
        end
        chk(xfer_done, "R8 done after last item", 32'(xfer_done), 32'd1);
        chk(nrd == int'(v.cnt) && nwr == int'(v.cnt), "R1 one read and one write per item",
            32'(nrd), 32'(v.cnt));
        // R4: direction selects which side is source
        sb = v.dir ? v.mb : v.pb;  db = v.dir ? v.pb : v.mb;
        ss = v.dir ? v.ms : v.ps;  ds = v.dir ? v.ps : v.ms;
        si = v.dir ? v.mi : v.pi;  di = v.dir ? v.pi : v.mi;
        for (int i = 0; i < int'(v.cnt); i++) begin
            sa = sb + (si ? 32'(i) * (32'd1 << ss) : 32'd0);
            da = db + (di ? 32'(i) * (32'd1 << ds) : 32'd0);
            ed = mem_model(sa) & mask_of(ss) & mask_of(ds);
            if (i == 0) begin
                chk(rd_addr[i] == sb, "R1 first read at source base", rd_addr[i], sb);
                chk(wr_addr[i] == db, "R1 first write at dest base", wr_addr[i], db);
            end
            chk(rd_addr[i] == sa, (si ? "R2 source stride" : "R3 source fixed"), rd_addr[i], sa);
            chk(wr_addr[i] == da, (di ? "R2 dest stride" : "R3 dest fixed"), wr_addr[i], da);
            chk(rd_addr[i][31:28] == (v.dir ? 4'h2 : 4'h4), "R4 read side", rd_addr[i], sb);
            chk(wr_data[i] == ed, "R5 data masked to both widths", wr_data[i], ed);
            chk(rd_size[i] == ss && wr_size[i] == ds, "R5 beat size codes",
                32'({rd_size[i], wr_size[i]}), 32'({ss, ds}));
        end
        // R8: request arriving as the final ack falls is ignored
        periph_req = 1'b1;
        repeat (4) @(negedge clk);
        chk(nrd == int'(v.cnt) && !periph_ack, "R8 request ignored after done", 32'(nrd), 32'(v.cnt));
        chk(xfer_done, "R8 done stays high", 32'(xfer_done), 32'd1);
        periph_req = 1'b0;
        chan_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] left0;
        rst_n = 1'b0;
        chan_en = 1'b0;
        periph_req = 1'b0;
        apply_cfg(VECS[0]);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!xfer_done && !periph_ack && !bus_valid, "R13 reset outputs idle",
            32'({xfer_done, periph_ack, bus_valid}), 32'd0);
        chk(items_left == 16'd0, "R13 reset count", 32'(items_left), 32'd0);

        for (int k = 0; k < NVEC; k++) begin
            run_vec(VECS[k]);
        end

        // R11: restart from base addresses
        apply_cfg(VECS[0]);
        nrd = 0;
        nwr = 0;
        chan_en = 1'b1;
        @(negedge clk);
        chk(items_left == 16'd4, "R11 count reloaded", 32'(items_left), 32'd4);
        do_item(16'd3);
        chk(rd_addr[0] == VECS[0].pb, "R11 restart read at base", rd_addr[0], VECS[0].pb);
        chk(wr_addr[0] == VECS[0].mb, "R11 restart write at base", wr_addr[0], VECS[0].mb);
        chan_en = 1'b0;
        @(negedge clk);
        chk(!bus_valid && !xfer_done, "R11 disable returns idle", 32'(bus_valid), 32'd0);

        // R9: zero count
        item_count = 16'd0;
        nrd = 0;
        nwr = 0;
        chan_en = 1'b1;
        @(negedge clk);
        chk(xfer_done, "R9 zero count done at once", 32'(xfer_done), 32'd1);
        periph_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(nrd == 0 && nwr == 0 && !bus_valid, "R9 no bus beat", 32'(nrd + nwr), 32'd0);
        periph_req = 1'b0;
        chan_en = 1'b0;
        @(negedge clk);

        // R10: reserved size code 11 on either side
        for (int side = 0; side < 2; side++) begin
            apply_cfg(VECS[4]);
            if (side == 0) periph_size = 2'b11; else mem_size = 2'b11;
            left0 = items_left;
            nrd = 0;
            chan_en = 1'b1;
            periph_req = 1'b1;
            repeat (5) @(negedge clk);
            chk(nrd == 0 && !periph_ack && !xfer_done, "R10 reserved size stays idle",
                32'(nrd), 32'd0);
            chk(items_left == left0, "R10 count untouched", 32'(items_left), 32'(left0));
            periph_req = 1'b0;
            chan_en = 1'b0;
            @(negedge clk);
        end

        // R6: full 16-bit count
        apply_cfg(VECS[5]);
        item_count = 16'hFFFF;
        chan_en = 1'b1;
        @(negedge clk);
        chk(items_left == 16'hFFFF, "R6 full width load", 32'(items_left), 32'h0000_FFFF);
        do_item(16'hFFFE);
        chan_en = 1'b0;
        @(negedge clk);
        chk(!bus_valid && !xfer_done, "R6 disable mid transfer", 32'(bus_valid), 32'd0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule